// File: doc/BRIEF.md
# Integer ALU with shared condition bit

A purely combinational 32-bit execution unit for a two-operand register machine. Each cycle it receives an already decoded operation code, the value of the destination register, the value of the source register, a 16-bit immediate, a 5-bit immediate and the machine's single architectural condition bit. It returns the value to write back to the destination register together with a write enable, and the next value of the condition bit together with its own write enable.

Add, subtract and negate share one adder. The condition bit serves two purposes. Overflow-checking add and subtract load it with signed overflow. Carry-chained add and subtract take it as carry-in or borrow-in and write the new carry or borrow back into it. This lets software build wide arithmetic from repeated 32-bit steps. One barrel shifter serves three shift flavours, each with three amount sources. The surrounding pipeline registers the outputs and owns the register file.

Top module: `alu_cond_unit`

## Requirements
- R1: Code 0 yields dst+src and code 1 yields dst-src (modulo 2^32). Neither writes the condition bit: cond_we_o=0 and cond_o=cond_i.
- R2: Code 2 yields dst+src and writes the condition bit with the signed overflow of that sum, taken with a carry-in of zero.
- R3: Code 3 yields dst-src and writes the condition bit with the signed overflow of that difference, taken with a borrow-in of zero.
- R4: Code 4 yields dst+src+cond_i and writes the carry-out of that 32-bit unsigned sum into the condition bit.
- R5: Code 5 yields dst-src-cond_i and writes the borrow-out into the condition bit. The borrow-out is 1 when the unsigned true difference is negative.
- R6: Code 6 yields the two's complement of src. Code 7 yields the bitwise complement of src. Code 8 copies src.
- R7: Codes 9, 10 and 11 shift dst left logically, right logically and right arithmetically. The amount is src AND 31, and the upper bits of src are ignored.
- R8: Codes 12, 13 and 14 are the same three shifts applied to src. The amount is imm16_i AND 31.
- R9: Codes 15, 16 and 17 are the same three shifts applied to dst. The amount is the unsigned imm5_i.
- R10: Code 18 yields imm16_i in the upper half with the lower 16 bits zero.
- R11: A shift amount of zero passes the operand through unchanged. An arithmetic right shift fills with the operand's sign bit. The logical shifts fill with zero.
- R12: cond_we_o is 1 only for codes 2 to 5. Whenever cond_we_o is 0, cond_o equals cond_i.
- R13: result_we_o is 1 for codes 0 to 18. Codes 19 to 31 are unassigned: result_we_o=0, cond_we_o=0 and result_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Decoded operation code |
| dst_i | input | 32 | Destination register value (first operand) |
| src_i | input | 32 | Source register value |
| imm16_i | input | 16 | 16-bit immediate |
| imm5_i | input | 5 | Unsigned 5-bit shift immediate |
| cond_i | input | 1 | Current condition bit |
| result_o | output | 32 | Value for the destination register |
| result_we_o | output | 1 | Destination write enable |
| cond_o | output | 1 | Next condition bit |
| cond_we_o | output | 1 | Condition bit write enable |

## Verification
The block holds no state, so every fault shows on the outputs in the same cycle as the operation that exposes it. The real risk sits with the condition bit. A wrongly steered carry-in, an inverted borrow or an overflow taken from the wrong bit leaves the result correct while the condition bit is wrong. Such a fault would surface only in the next chained step, so the condition output is compared on every vector, with operands chosen at the signed and unsigned wrap points. Shift masking is exercised with source values whose bits above bit 4 are set, so that an unmasked amount produces a visibly different result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_ADDV  = 5'd2,
    OP_SUBV  = 5'd3,
    OP_ADDX  = 5'd4,
    OP_SUBX  = 5'd5,
    OP_NEG   = 5'd6,
    OP_NOT   = 5'd7,
    OP_MV    = 5'd8,
    OP_SLL   = 5'd9,
    OP_SRL   = 5'd10,
    OP_SRA   = 5'd11,
    OP_SLL3  = 5'd12,
    OP_SRL3  = 5'd13,
    OP_SRA3  = 5'd14,
    OP_SLLI  = 5'd15,
    OP_SRLI  = 5'd16,
    OP_SRAI  = 5'd17,
    OP_SETH  = 5'd18
  } op_e;

  typedef enum logic [1:0] {
    SH_LL = 2'd0,
    SH_RL = 2'd1,
    SH_RA = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;
  logic         c_into_msb;

  always_comb begin
    b_eff      = inv_i ? ~b_i : b_i;
    full       = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
    sum_o      = full[W-1:0];
    carry_o    = full[W];
    // carry into sign position recovered from the sum bit
    c_into_msb = full[W-1] ^ a_i[W-1] ^ b_eff[W-1];
    ovf_o      = c_into_msb ^ full[W];
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W       = 32,
  parameter int SHAMT_W = $clog2(W)
) (
  input  logic [W-1:0]       val_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  shift_kind_e        kind_i,
  output logic [W-1:0]       val_o
);
  logic         left;
  logic         fill;
  logic [W-1:0] rev_in;
  logic [W-1:0] core_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] stage [SHAMT_W+1];

  assign left = (kind_i == SH_LL);
  assign fill = (kind_i == SH_RA) ? val_i[W-1] : 1'b0;

  // left shift done as right shift on bit-reversed data
  for (genvar b = 0; b < W; b++) begin : g_rev
    assign rev_in[b]  = val_i[W-1-b];
    assign rev_out[b] = stage[SHAMT_W][W-1-b];
  end

  assign core_in  = left ? rev_in : val_i;
  assign stage[0] = core_in;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
  end

  assign val_o = left ? rev_out : stage[SHAMT_W];
endmodule

// File: rtl/alu_cond_unit.sv
module alu_cond_unit
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int OP_W    = 5,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [OP_W-1:0]    op_i,
  input  logic [DATA_W-1:0]  dst_i,
  input  logic [DATA_W-1:0]  src_i,
  input  logic [IMM_W-1:0]   imm16_i,
  input  logic [SHAMT_W-1:0] imm5_i,
  input  logic               cond_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               result_we_o,
  output logic               cond_o,
  output logic               cond_we_o
);
  localparam int LOW_W = DATA_W - IMM_W;

  op_e                op;
  logic [DATA_W-1:0]  add_a, add_b, add_sum;
  logic               add_inv, add_cin, add_carry, add_ovf;
  logic [DATA_W-1:0]  sh_val, sh_res;
  logic [SHAMT_W-1:0] sh_amt;
  shift_kind_e        sh_kind;
  logic [DATA_W-1:0]  seth_val;
  logic               new_cond;

  assign op       = op_e'(op_i);
  assign seth_val = {imm16_i, {LOW_W{1'b0}}};

  // operand steering for the shared adder and shifter
  always_comb begin
    add_a   = dst_i;
    add_b   = src_i;
    add_inv = 1'b0;
    add_cin = 1'b0;
    sh_val  = dst_i;
    sh_amt  = src_i[SHAMT_W-1:0];
    sh_kind = SH_LL;
    case (op)
      OP_SUB, OP_SUBV: begin
        add_inv = 1'b1;
        add_cin = 1'b1;
      end
      OP_ADDX: add_cin = cond_i;
      OP_SUBX: begin
        add_inv = 1'b1;
        add_cin = ~cond_i;
      end
      OP_NEG: begin
        add_a   = '0;
        add_inv = 1'b1;
        add_cin = 1'b1;
      end
      OP_SRL: sh_kind = SH_RL;
      OP_SRA: sh_kind = SH_RA;
      OP_SLL3, OP_SRL3, OP_SRA3: begin
        sh_val  = src_i;
        sh_amt  = imm16_i[SHAMT_W-1:0];
        sh_kind = (op == OP_SLL3) ? SH_LL : (op == OP_SRL3) ? SH_RL : SH_RA;
      end
      OP_SLLI, OP_SRLI, OP_SRAI: begin
        sh_amt  = imm5_i;
        sh_kind = (op == OP_SLLI) ? SH_LL : (op == OP_SRLI) ? SH_RL : SH_RA;
      end
      default: ;
    endcase
  end

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i     (add_a),
    .b_i     (add_b),
    .inv_i   (add_inv),
    .cin_i   (add_cin),
    .sum_o   (add_sum),
    .carry_o (add_carry),
    .ovf_o   (add_ovf)
  );

  alu_shifter #(.W(DATA_W), .SHAMT_W(SHAMT_W)) u_shifter (
    .val_i  (sh_val),
    .amt_i  (sh_amt),
    .kind_i (sh_kind),
    .val_o  (sh_res)
  );

  // result select and write enables
  always_comb begin
    result_o    = '0;
    result_we_o = 1'b1;
    cond_we_o   = 1'b0;
    new_cond    = cond_i;
    case (op)
      OP_ADD, OP_SUB, OP_NEG: result_o = add_sum;
      OP_ADDV, OP_SUBV: begin
        result_o  = add_sum;
        new_cond  = add_ovf;
        cond_we_o = 1'b1;
      end
      OP_ADDX: begin
        result_o  = add_sum;
        new_cond  = add_carry;
        cond_we_o = 1'b1;
      end
      OP_SUBX: begin
        result_o  = add_sum;
        new_cond  = ~add_carry;
        cond_we_o = 1'b1;
      end
      OP_NOT:  result_o = ~src_i;
      OP_MV:   result_o = src_i;
      OP_SLL, OP_SRL, OP_SRA, OP_SLL3, OP_SRL3, OP_SRA3,
      OP_SLLI, OP_SRLI, OP_SRAI: result_o = sh_res;
      OP_SETH: result_o = seth_val;
      default: result_we_o = 1'b0;
    endcase
    cond_o = new_cond;
  end
endmodule

// File: rtl/alu_cond_unit_chk.sv
module alu_cond_unit_chk #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 5
) (
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic              cond_i,
  input logic [DATA_W-1:0] result_o,
  input logic              result_we_o,
  input logic              cond_o,
  input logic              cond_we_o
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    if (!$isunknown({op_i, dst_i, src_i, cond_i, result_o, result_we_o, cond_o, cond_we_o})) begin
      // R12
      cond_we_scope_chk: assert (!cond_we_o || (op_i >= OP_W'(2) && op_i <= OP_W'(5)));
      // R1
      cond_hold_chk: assert (cond_we_o || (cond_o == cond_i));
      // R13
      idle_op_chk: assert ((op_i <= OP_W'(18)) || (!result_we_o && !cond_we_o && result_o == '0));
      // R10
      seth_low_zero_chk: assert (op_i != OP_W'(18) || result_o[HALF-1:0] == '0);
      // R6
      neg_sum_chk: assert (op_i != OP_W'(6) || (result_o + src_i) == '0);
      // R4
      addx_chain_chk: assert (op_i != OP_W'(4) ||
        {cond_o, result_o} == ({1'b0, dst_i} + {1'b0, src_i} + {{DATA_W{1'b0}}, cond_i}));
    end
  end
endmodule

bind alu_cond_unit alu_cond_unit_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
  .op_i        (op_i),
  .dst_i       (dst_i),
  .src_i       (src_i),
  .cond_i      (cond_i),
  .result_o    (result_o),
  .result_we_o (result_we_o),
  .cond_o      (cond_o),
  .cond_we_o   (cond_we_o)
);

// File: tb/alu_cond_unit_test.sv
`timescale 1ns/1ps
module alu_cond_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op_i = 5'd31;
  logic [31:0] dst_i = '0, src_i = '0;
  logic [15:0] imm16_i = '0;
  logic [4:0]  imm5_i = '0;
  logic        cond_i = 1'b0;
  logic [31:0] result_o;
  logic        result_we_o, cond_o, cond_we_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu_cond_unit uut (
    .op_i(op_i), .dst_i(dst_i), .src_i(src_i), .imm16_i(imm16_i), .imm5_i(imm5_i),
    .cond_i(cond_i), .result_o(result_o), .result_we_o(result_we_o),
    .cond_o(cond_o), .cond_we_o(cond_we_o)
  );

  function automatic string req_of(int op);
    if (op <= 1) return "R1";
    if (op == 2) return "R2";
    if (op == 3) return "R3";
    if (op == 4) return "R4";
    if (op == 5) return "R5";
    if (op <= 8) return "R6";
    if (op <= 11) return "R7";
    if (op <= 14) return "R8";
    if (op <= 17) return "R9";
    if (op == 18) return "R10";
    return "R13";
  endfunction

  task automatic model(input int op, input logic [31:0] d, input logic [31:0] s,
                       input logic [15:0] i16, input logic [4:0] i5, input logic c,
                       output logic [31:0] r, output logic rwe, output logic cn, output logic cwe);
    longint sd, ss, t;
    logic [31:0] v;
    int amt, kind;
    sd = longint'($signed(d));
    ss = longint'($signed(s));
    r = 0; rwe = 1; cn = c; cwe = 0;
    kind = -1; v = d; amt = 0;
    case (op)
      0: r = d + s;
      1: r = d - s;
      2: begin t = sd + ss; r = t[31:0]; cwe = 1; cn = (t > 64'sd2147483647 || t < -64'sd2147483648); end
      3: begin t = sd - ss; r = t[31:0]; cwe = 1; cn = (t > 64'sd2147483647 || t < -64'sd2147483648); end
      4: begin t = longint'(d) + longint'(s) + longint'(c); r = t[31:0]; cwe = 1; cn = (t >= 64'sd4294967296); end
      5: begin t = longint'(d) - longint'(s) - longint'(c); r = t[31:0]; cwe = 1; cn = (t < 0); end
      6: r = 32'd0 - s;
      7: r = ~s;
      8: r = s;
      9, 10, 11: begin v = d; amt = int'(s % 32); kind = op - 9; end
      12, 13, 14: begin v = s; amt = int'(i16 % 16'd32); kind = op - 12; end
      15, 16, 17: begin v = d; amt = int'(i5); kind = op - 15; end
      18: r = {i16, 16'h0000};
      default: rwe = 0;
    endcase
    if (kind == 0) r = v << amt;
    else if (kind == 1) r = v >> amt;
    else if (kind == 2) r = $unsigned($signed(v) >>> amt);
  endtask

  task automatic run(input int op, input logic [31:0] d, input logic [31:0] s,
                     input logic [15:0] i16, input logic [4:0] i5, input logic c, input string tag);
    logic [31:0] er; logic erwe, ecn, ecwe;
    @(posedge clk); #1;
    op_i = op[4:0]; dst_i = d; src_i = s; imm16_i = i16; imm5_i = i5; cond_i = c;
    model(op, d, s, i16, i5, c, er, erwe, ecn, ecwe);
    @(negedge clk);
    n_chk++;
    if (result_o !== er || result_we_o !== erwe || cond_o !== ecn || cond_we_o !== ecwe) begin
      n_fail++;
      $display("FAIL %s op=%0d d=%h s=%h i16=%h i5=%0d c=%b: got res=%h we=%b c=%b cwe=%b exp res=%h we=%b c=%b cwe=%b",
               tag, op, d, s, i16, i5, c, result_o, result_we_o, cond_o, cond_we_o, er, erwe, ecn, ecwe);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // R13 idle code at start: nothing written
    run(31, 32'h1234_5678, 32'h9abc_def0, 16'h55aa, 5'd3, 1'b1, "R13");
    // R1 plain forms keep condition bit
    run(0, 32'hffff_ffff, 32'h1, 16'h0, 5'd0, 1'b1, "R1");
    run(1, 32'h0, 32'h1, 16'h0, 5'd0, 1'b0, "R1");
    // R2 overflow at signed wrap
    run(2, 32'h7fff_ffff, 32'h1, 16'h0, 5'd0, 1'b0, "R2");
    run(2, 32'h8000_0000, 32'h8000_0000, 16'h0, 5'd0, 1'b1, "R2");
    run(2, 32'hffff_ffff, 32'h1, 16'h0, 5'd0, 1'b1, "R2");
    // R3
    run(3, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 1'b0, "R3");
    run(3, 32'h0, 32'h8000_0000, 16'h0, 5'd0, 1'b0, "R3");
    run(3, 32'h5, 32'h7, 16'h0, 5'd0, 1'b1, "R3");
    // R4 carry chain
    run(4, 32'hffff_ffff, 32'h0, 16'h0, 5'd0, 1'b1, "R4");
    run(4, 32'hffff_fffe, 32'h1, 16'h0, 5'd0, 1'b0, "R4");
    // R5 borrow chain
    run(5, 32'h0, 32'h0, 16'h0, 5'd0, 1'b1, "R5");
    run(5, 32'h1, 32'h0, 16'h0, 5'd0, 1'b1, "R5");
    run(5, 32'h5, 32'h6, 16'h0, 5'd0, 1'b0, "R5");
    // R6
    run(6, 32'h0, 32'h8000_0000, 16'h0, 5'd0, 1'b0, "R6");
    run(7, 32'h0, 32'h0f0f_00ff, 16'h0, 5'd0, 1'b1, "R6");
    run(8, 32'hdead_beef, 32'h0bad_f00d, 16'h0, 5'd0, 1'b0, "R6");
    // R7 masking: src upper bits set
    run(9, 32'h0000_0003, 32'hffff_ffe4, 16'h0, 5'd0, 1'b0, "R7");
    run(11, 32'h8000_0010, 32'h0000_0124, 16'h0, 5'd0, 1'b0, "R7");
    // R8 amount from imm16, operand src
    run(13, 32'hffff_ffff, 32'h8000_0000, 16'hffe8, 5'd0, 1'b0, "R8");
    run(14, 32'h0, 32'h8000_0000, 16'h001f, 5'd0, 1'b0, "R8");
    // R9
    run(15, 32'h1, 32'hffff_ffff, 16'hffff, 5'd31, 1'b0, "R9");
    run(16, 32'h8000_0000, 32'h0, 16'h0, 5'd31, 1'b0, "R9");
    // R11 zero amount, sign fill
    run(17, 32'h8765_4321, 32'h0, 16'h0, 5'd0, 1'b0, "R11");
    run(10, 32'h8765_4321, 32'h0000_0020, 16'h0, 5'd0, 1'b0, "R11");
    run(17, 32'h8000_0000, 32'h0, 16'h0, 5'd4, 1'b0, "R11");
    // R10
    run(18, 32'hffff_ffff, 32'hffff_ffff, 16'hbeef, 5'd0, 1'b1, "R10");
    // R12/R13 every code, random operands
    for (int rep = 0; rep < 200; rep++) begin
      for (int op = 0; op < 32; op++) begin
        logic [31:0] d, s;
        d = $urandom;
        s = $urandom;
        if (rep % 4 == 0) d = {d[31], 31'h7fff_fff0} | d[3:0];
        run(op, d, s, 16'($urandom), 5'($urandom), 1'($urandom),
            (op >= 19) ? "R13" : (op >= 2 && op <= 5) ? req_of(op) : "R12");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule